// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms the data-memory address for each load or store of a small 8-bit core. The address comes either from a 16-bit constant carried in the instruction or from one of three 16-bit pointers. Each pointer is built from a pair of general registers. A pointer can be used as it stands, plus a 6-bit unsigned displacement, decremented before the access, or incremented after it.

The register file sits outside this block. It presents the three pointer values and accepts the write-back that the auto-update modes produce. The write-back is given as a low byte, a high byte and the number of the even register that receives the low byte.

Every access result is registered. It appears one cycle after the request, together with a decode of which data region the address falls in. A separate combinational output turns an I/O register number into its data-space address.

Top module: `dm_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs `acc_o`, `err_o`, `wb_en_o`, `addr_o`, `region_o`, `wb_lo_idx_o`, `wb_lo_o` and `wb_hi_o` are all zero.
- R2: Mode 0 (direct) gives `addr_o` equal to `direct_i`, takes no pointer, and never asserts write-back. The value of `sel_i` is ignored in this mode.
- R3: Mode 1 (indirect) gives `addr_o` equal to the selected pointer and does not write back. Select code 0 picks X, 1 picks Y and 2 picks Z.
- R4: Mode 2 (displacement) gives `addr_o` as the selected pointer plus `disp_i` (0 to 63), wrapping modulo 65536. It does not write back, and it is legal only with Y or Z.
- R5: Mode 3 (pre-decrement) gives `addr_o` as the pointer minus one, wrapping modulo 65536. It writes that same value back to the pointer.
- R6: Mode 4 (post-increment) gives `addr_o` as the unchanged pointer. It writes back the pointer plus one, wrapping modulo 65536.
- R7: A write-back lasts exactly one cycle per access. `wb_lo_o` and `wb_hi_o` carry the low and high bytes of the new pointer. `wb_lo_idx_o` is 26 for X, 28 for Y and 30 for Z. The high byte goes to the register numbered `wb_lo_idx_o`+1.
- R8: `region_o` is 0 for addresses 0x0000 to 0x001F (general registers), 1 for 0x0020 to 0x005F (I/O registers) and 2 for 0x0060 and above (SRAM).
- R9: `io_addr_o` equals `io_num_i` + 0x20, combinationally, for every I/O number 0 to 63.
- R10: Some requests are illegal: mode codes 5 to 7, select code 3 in any pointer mode, or mode 2 with X. An illegal request raises `err_o` for one cycle, with `acc_o` and `wb_en_o` low.
- R11: Results appear on the clock edge after the `valid_i` request. In any cycle that follows a cycle without a request, `acc_o`, `err_o` and `wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Access request this cycle |
| mode_i | input | 3 | Addressing mode code |
| sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| disp_i | input | 6 | Unsigned displacement |
| direct_i | input | 16 | Direct address constant |
| ptr_x_i | input | 16 | X pointer value (R27:R26) |
| ptr_y_i | input | 16 | Y pointer value (R29:R28) |
| ptr_z_i | input | 16 | Z pointer value (R31:R30) |
| io_num_i | input | 6 | I/O register number to translate |
| io_addr_o | output | 16 | Data-space address of that I/O register |
| acc_o | output | 1 | Legal access result valid |
| err_o | output | 1 | Illegal request flagged |
| addr_o | output | 16 | Effective address |
| region_o | output | 2 | 0 registers, 1 I/O, 2 SRAM |
| wb_en_o | output | 1 | Pointer write-back strobe |
| wb_lo_idx_o | output | 5 | Register number receiving the low byte |
| wb_lo_o | output | 8 | New pointer low byte |
| wb_hi_o | output | 8 | New pointer high byte |

## Verification
Address formation, region decode and pointer write-back all land in the same result cycle, and they can disagree at the edges of the map. A pre-decrement of 0x0060 gives an I/O address while writing back 0x005F. A pre-decrement of 0x0000 wraps to an SRAM address of 0xFFFF. A post-increment of 0xFFFF uses an SRAM address while writing back 0x0000. The sweep rotates boundary values through X, Y and Z under every mode, select and displacement. In each result cycle it judges the address, region, byte split and register number together against values computed from the requirements.

// File: rtl/dm_addr_gen.sv
module dm_addr_gen #(
  parameter int QW      = 6,
  parameter int IOW     = 6,
  parameter int RF_END  = 32,
  parameter int IO_END  = 96
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic [2:0]     mode_i,
  input  logic [1:0]     sel_i,
  input  logic [QW-1:0]  disp_i,
  input  logic [15:0]    direct_i,
  input  logic [15:0]    ptr_x_i,
  input  logic [15:0]    ptr_y_i,
  input  logic [15:0]    ptr_z_i,
  input  logic [IOW-1:0] io_num_i,
  output logic [15:0]    io_addr_o,
  output logic           acc_o,
  output logic           err_o,
  output logic [15:0]    addr_o,
  output logic [1:0]     region_o,
  output logic           wb_en_o,
  output logic [4:0]     wb_lo_idx_o,
  output logic [7:0]     wb_lo_o,
  output logic [7:0]     wb_hi_o
);
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_DSP = 3'd2,
                         M_PRE = 3'd3, M_PST = 3'd4;
  localparam logic [15:0] RF_LIM = 16'(RF_END);
  localparam logic [15:0] IO_LIM = 16'(IO_END);

  logic [15:0] ptr, nxt_addr, nxt_wb;
  logic        bad, do_wb;

  assign io_addr_o = 16'(io_num_i) + RF_LIM;

  always_comb begin
    case (sel_i)
      2'd0:    ptr = ptr_x_i;
      2'd1:    ptr = ptr_y_i;
      2'd2:    ptr = ptr_z_i;
      default: ptr = '0;
    endcase
  end

  assign bad = (mode_i > M_PST)
             || (mode_i != M_DIR && sel_i == 2'd3)
             || (mode_i == M_DSP && sel_i == 2'd0);

  always_comb begin
    nxt_addr = ptr;
    nxt_wb   = ptr;
    do_wb    = 1'b0;
    case (mode_i)
      M_DIR: nxt_addr = direct_i;
      M_IND: nxt_addr = ptr;
      M_DSP: nxt_addr = ptr + 16'(disp_i);
      M_PRE: begin
        nxt_addr = ptr - 16'd1;
        nxt_wb   = ptr - 16'd1;
        do_wb    = 1'b1;
      end
      M_PST: begin
        nxt_addr = ptr;
        nxt_wb   = ptr + 16'd1;
        do_wb    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o       <= 1'b0;
      err_o       <= 1'b0;
      addr_o      <= '0;
      region_o    <= '0;
      wb_en_o     <= 1'b0;
      wb_lo_idx_o <= '0;
      wb_lo_o     <= '0;
      wb_hi_o     <= '0;
    end else begin
      acc_o   <= valid_i && !bad;
      err_o   <= valid_i && bad;
      wb_en_o <= valid_i && !bad && do_wb;
      if (valid_i && !bad) begin
        addr_o      <= nxt_addr;
        region_o    <= (nxt_addr < RF_LIM) ? 2'd0 :
                       (nxt_addr < IO_LIM) ? 2'd1 : 2'd2;
        wb_lo_idx_o <= 5'd26 + {2'b00, sel_i, 1'b0};
        wb_lo_o     <= nxt_wb[7:0];
        wb_hi_o     <= nxt_wb[15:8];
      end
    end
  end
endmodule

module dm_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [2:0]  mode_i,
  input logic [1:0]  sel_i,
  input logic        acc_o,
  input logic        err_o,
  input logic [15:0] addr_o,
  input logic        wb_en_o,
  input logic [4:0]  wb_lo_idx_o,
  input logic [7:0]  wb_lo_o,
  input logic [7:0]  wb_hi_o
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i) |-> (!acc_o && !err_o && !wb_en_o));
  // R10
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!acc_o && !wb_en_o));
  // R5
  predec_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && mode_i == 3'd3 && sel_i != 2'd3)
      |-> (wb_en_o && {wb_hi_o, wb_lo_o} == addr_o));
  // R6
  postinc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && mode_i == 3'd4 && sel_i != 2'd3)
      |-> (wb_en_o && {wb_hi_o, wb_lo_o} == addr_o + 16'd1));
  // R4
  disp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i == 3'd2 || mode_i == 3'd1 || mode_i == 3'd0) |-> !wb_en_o);
  // R7
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |=> (!wb_en_o || $past(valid_i)));
  // R7
  wb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_lo_idx_o == 5'd26 || wb_lo_idx_o == 5'd28 || wb_lo_idx_o == 5'd30));
endmodule

bind dm_addr_gen dm_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i), .sel_i(sel_i),
  .acc_o(acc_o), .err_o(err_o), .addr_o(addr_o), .wb_en_o(wb_en_o),
  .wb_lo_idx_o(wb_lo_idx_o), .wb_lo_o(wb_lo_o), .wb_hi_o(wb_hi_o)
);

// File: tb/dm_addr_gen_tb.sv
`timescale 1ns/1ps
module dm_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  sel_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] direct_i = '0;
  logic [15:0] ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic [5:0]  io_num_i = '0;
  logic [15:0] io_addr_o, addr_o;
  logic        acc_o, err_o, wb_en_o;
  logic [1:0]  region_o;
  logic [4:0]  wb_lo_idx_o;
  logic [7:0]  wb_lo_o, wb_hi_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dm_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i), .sel_i(sel_i),
    .disp_i(disp_i), .direct_i(direct_i), .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i),
    .ptr_z_i(ptr_z_i), .io_num_i(io_num_i), .io_addr_o(io_addr_o), .acc_o(acc_o),
    .err_o(err_o), .addr_o(addr_o), .region_o(region_o), .wb_en_o(wb_en_o),
    .wb_lo_idx_o(wb_lo_idx_o), .wb_lo_o(wb_lo_o), .wb_hi_o(wb_hi_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] region_of(input logic [15:0] a);
    if (a <= 16'h001F) return 2'd0;
    if (a <= 16'h005F) return 2'd1;
    return 2'd2;
  endfunction

  task automatic access(input logic [2:0] m, input logic [1:0] s, input logic [5:0] q,
                        input logic [15:0] d);
    logic [15:0] p, ea, nw;
    logic bad, wb;
    string rq;
    p = (s == 2'd0) ? ptr_x_i : (s == 2'd1) ? ptr_y_i : ptr_z_i;
    bad = (m > 3'd4) || (m != 3'd0 && s == 2'd3) || (m == 3'd2 && s == 2'd0);
    wb = !bad && (m == 3'd3 || m == 3'd4);
    nw = p;
    case (m)
      3'd0: begin ea = d; rq = "R2"; end
      3'd1: begin ea = p; rq = "R3"; end
      3'd2: begin ea = p + {10'd0, q}; rq = "R4"; end
      3'd3: begin ea = p - 16'd1; nw = ea; rq = "R5"; end
      3'd4: begin ea = p; nw = p + 16'd1; rq = "R6"; end
      default: begin ea = '0; rq = "R10"; end
    endcase
    if (bad) rq = "R10";
    mode_i = m; sel_i = s; disp_i = q; direct_i = d; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk(acc_o == !bad, rq, "acc", int'(acc_o), int'(!bad));
    chk(err_o == bad, "R10", "err", int'(err_o), int'(bad));
    chk(wb_en_o == wb, rq, "wb_en", int'(wb_en_o), int'(wb));
    if (!bad) begin
      chk(addr_o == ea, rq, "addr", int'(addr_o), int'(ea));
      chk(region_o == region_of(ea), "R8", "region", int'(region_o), int'(region_of(ea)));
    end
    if (wb) begin
      chk({wb_hi_o, wb_lo_o} == nw, rq, "wb value", int'({wb_hi_o, wb_lo_o}), int'(nw));
      chk(wb_lo_idx_o == 5'(26 + 2 * s), "R7", "wb idx", int'(wb_lo_idx_o), 26 + 2 * s);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!acc_o && !err_o && !wb_en_o, "R11", "idle strobes",
        int'({acc_o, err_o, wb_en_o}), 0);
    chk(!wb_en_o, "R7", "wb one-cycle", int'(wb_en_o), 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [10];
    logic [5:0]  qs [4];
    vals = '{16'h0000, 16'h0001, 16'h001F, 16'h0020, 16'h005F,
             16'h0060, 16'h0061, 16'hFFFF, 16'h1234, 16'hFFC1};
    qs = '{6'd0, 6'd1, 6'd31, 6'd63};

    repeat (3) @(negedge clk);
    chk({acc_o, err_o, wb_en_o} == 3'b000, "R1", "strobes in reset",
        int'({acc_o, err_o, wb_en_o}), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(addr_o == 16'h0 && region_o == 2'd0, "R1", "addr/region after reset",
        int'({addr_o, region_o}), 0);
    chk({wb_lo_idx_o, wb_lo_o, wb_hi_o} == '0, "R1", "wb fields after reset",
        int'({wb_lo_idx_o, wb_lo_o, wb_hi_o}), 0);
    chk(!acc_o && !err_o && !wb_en_o, "R1", "strobes after reset",
        int'({acc_o, err_o, wb_en_o}), 0);

    for (int n = 0; n < 64; n++) begin
      io_num_i = 6'(n);
      #1;
      chk(io_addr_o == 16'(n + 32), "R9", "io translation", int'(io_addr_o), n + 32);
    end

    for (int i = 0; i < 10; i++) begin
      ptr_x_i = vals[i];
      ptr_y_i = vals[(i + 1) % 10];
      ptr_z_i = vals[(i + 2) % 10];
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 4; k++)
            access(3'(m), 2'(s), qs[k], vals[(i + k + 3) % 10]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule